// File: doc/BRIEF.md
# ASCII hexadecimal record loader

This block takes text in the common ASCII hexadecimal object-record format, one character per beat, and turns it into memory writes. A record starts at a colon. It then carries a byte count, a 16-bit load address, a record type, that many data bytes and a one-byte checksum. Each field is sent as pairs of hex digits, high nibble first. Each data byte is written out with its address as soon as its second digit arrives. The memory that takes these writes sits outside the block.

The block keeps a running 8-bit sum of every byte in a record. When the checksum digit pair arrives, it reports the record as done and flags any mismatch. Data records (type 0x00) are stored. The end-of-file record (type 0x01) stops the loader until reset. The extended-address types 0x02 to 0x05 are reported as unsupported and skipped. Malformed input is reported as a format error, and the loader then waits for the next colon.

The control machine has eight states. ST_HUNT waits for a colon. ST_COUNT, ST_ADDR_HI, ST_ADDR_LO and ST_TYPE each collect one header byte. ST_DATA collects the payload. ST_CSUM takes the checksum. ST_EOF absorbs all input until reset.

The transitions are as follows:
- colon in ST_HUNT goes to ST_COUNT;
- each completed byte steps through the header states in order;
- ST_TYPE goes to ST_DATA, or to ST_CSUM when the count is zero;
- the last data byte goes to ST_CSUM;
- ST_CSUM goes to ST_EOF on a good end-of-file record, and to ST_HUNT otherwise;
- any non-hex character, an oversized count or an unknown type returns to ST_HUNT;
- an unsupported type also returns to ST_HUNT.

Top module: `hexrec_parser`

## Requirements
- R1: After reset every pulse output (wr_en, rec_done, csum_err, fmt_err, unsup_type) is 0 and eof_seen is 0.
- R2: While waiting for a record, any character other than ':' (0x3A), including CR (0x0D) and LF (0x0A), produces no output.
- R3: A byte count above 0x10 raises fmt_err for one cycle, one cycle after its second digit. No write follows, and the loader waits for the next ':'.
- R4: In a type 0x00 record, each data byte pulses wr_en one cycle after its second digit. wr_data holds the byte and wr_addr holds the load address plus the byte's index, modulo 2^16. Hex digits 0-9, A-F and a-f are all accepted, high nibble first.
- R5: rec_done pulses for one cycle, one cycle after the second digit of the checksum byte.
- R6: When the 8-bit sum of count, both address bytes, type, data and checksum is not 0x00, csum_err pulses together with rec_done. Writes already made stand. The record with count 07, address 0020, type 00, data DB FE DC FA DD F6 22 and checksum 35 is accepted.
- R7: A character inside a record that is not a hex digit (including ':', CR or LF) raises fmt_err one cycle later. The loader returns to waiting for ':'.
- R8: A type 0x01 record with a good checksum sets eof_seen with its rec_done. eof_seen stays at 1 and every later character is ignored until reset. Data bytes of a type 0x01 record are never written.
- R9: Type values 0x02 to 0x05 pulse unsup_type one cycle after the type's second digit, and the rest of that record is skipped. Any type above 0x05 raises fmt_err instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| char_valid | input | 1 | char_data holds a character this cycle |
| char_data | input | 8 | ASCII character |
| wr_en | output | 1 | Write strobe for one data byte |
| wr_addr | output | 16 | Write address |
| wr_data | output | 8 | Write data |
| rec_done | output | 1 | Record checksum byte received |
| csum_err | output | 1 | Record checksum mismatch |
| fmt_err | output | 1 | Malformed record abandoned |
| unsup_type | output | 1 | Extended-address record type skipped |
| eof_seen | output | 1 | End-of-file record accepted (sticky) |

## Verification
The hardest case to reach is the quiet state after end of file. It only appears after a complete, correctly summed type 0x01 record, and from then on the block must stay silent even when fed well-formed records. The stimulus therefore builds every record with a checksum computed in the bench. It runs valid, corrupted and skipped records, so errors never leave a parse phase behind. It finishes with a good end-of-file record followed by a full data record, which must produce no write.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;
    typedef enum logic [2:0] {
        ST_HUNT,
        ST_COUNT,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_TYPE,
        ST_DATA,
        ST_CSUM,
        ST_EOF
    } state_t;

    localparam logic [7:0] CH_START  = 8'h3A;
    localparam logic [7:0] TYP_DATA  = 8'h00;
    localparam logic [7:0] TYP_EOF   = 8'h01;
    localparam logic [7:0] TYP_EXT_L = 8'h02;
    localparam logic [7:0] TYP_EXT_H = 8'h05;
endpackage

// File: rtl/hexrec_nibble_dec.sv
module hexrec_nibble_dec (
    input  logic [7:0] ch,
    output logic       is_hex,
    output logic [3:0] nib
);
    always_comb begin
        is_hex = 1'b1;
        nib    = 4'h0;
        if (ch >= 8'h30 && ch <= 8'h39)      nib = 4'(ch - 8'h30);
        else if (ch >= 8'h41 && ch <= 8'h46) nib = 4'(ch - 8'h37);
        else if (ch >= 8'h61 && ch <= 8'h66) nib = 4'(ch - 8'h57);
        else                                 is_hex = 1'b0;
    end
endmodule

// File: rtl/hexrec_byte_pair.sv
module hexrec_byte_pair (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       digit_en,
    input  logic [3:0] nib,
    output logic       byte_done,
    output logic [7:0] byte_val
);
    logic       phase_q;
    logic [3:0] hi_q;

    assign byte_done = digit_en && phase_q;
    assign byte_val  = {hi_q, nib};

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            phase_q <= 1'b0;
            hi_q    <= 4'h0;
        end else if (digit_en) begin
            phase_q <= ~phase_q;
            if (!phase_q) hi_q <= nib;
        end
    end
endmodule

// File: rtl/hexrec_sum_acc.sv
module hexrec_sum_acc #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         add_en,
    input  logic [W-1:0] add_val,
    output logic [W-1:0] sum_next
);
    logic [W-1:0] sum_q;

    assign sum_next = sum_q + add_val;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) sum_q <= '0;
        else if (add_en)     sum_q <= sum_next;
    end
endmodule

// File: rtl/hexrec_parser.sv
module hexrec_parser
    import hexrec_pkg::*;
#(
    parameter int MAX_COUNT = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        char_valid,
    input  logic [7:0]  char_data,
    output logic        wr_en,
    output logic [15:0] wr_addr,
    output logic [7:0]  wr_data,
    output logic        rec_done,
    output logic        csum_err,
    output logic        fmt_err,
    output logic        unsup_type,
    output logic        eof_seen
);
    localparam int         ADDR_W    = 16;
    localparam int         BYTE_W    = 8;
    localparam logic [7:0] MAX_CNT_B = 8'(MAX_COUNT);

    state_t              state_q, state_d;
    logic [BYTE_W-1:0]   cnt_q, cnt_d;
    logic [ADDR_W-1:0]   addr_q, addr_d;
    logic [BYTE_W-1:0]   type_q, type_d;

    logic                is_hex;
    logic [3:0]          nib;
    logic                in_rec, start, bad_char, digit_en;
    logic                byte_done;
    logic [BYTE_W-1:0]   byte_val;
    logic [BYTE_W-1:0]   sum_next;

    logic                wr_d, done_d, cerr_d, ferr_d, unsup_d;

    hexrec_nibble_dec u_dec (
        .ch     (char_data),
        .is_hex (is_hex),
        .nib    (nib)
    );

    assign in_rec   = (state_q != ST_HUNT) && (state_q != ST_EOF);
    assign start    = char_valid && (state_q == ST_HUNT) && (char_data == CH_START);
    assign bad_char = char_valid && in_rec && !is_hex;
    assign digit_en = char_valid && in_rec && is_hex;

    hexrec_byte_pair u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start),
        .digit_en  (digit_en),
        .nib       (nib),
        .byte_done (byte_done),
        .byte_val  (byte_val)
    );

    hexrec_sum_acc #(.W(BYTE_W)) u_sum (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start),
        .add_en   (byte_done),
        .add_val  (byte_val),
        .sum_next (sum_next)
    );

    // Next-state and next-output logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        addr_d  = addr_q;
        type_d  = type_q;
        wr_d    = 1'b0;
        done_d  = 1'b0;
        cerr_d  = 1'b0;
        ferr_d  = 1'b0;
        unsup_d = 1'b0;
        if (state_q == ST_HUNT) begin
            if (start) state_d = ST_COUNT;
        end else if (bad_char) begin
            ferr_d  = 1'b1;
            state_d = ST_HUNT;
        end else if (byte_done) begin
            unique case (state_q)
                ST_COUNT: begin
                    if (byte_val > MAX_CNT_B) begin
                        ferr_d  = 1'b1;
                        state_d = ST_HUNT;
                    end else begin
                        cnt_d   = byte_val;
                        state_d = ST_ADDR_HI;
                    end
                end
                ST_ADDR_HI: begin
                    addr_d[15:8] = byte_val;
                    state_d      = ST_ADDR_LO;
                end
                ST_ADDR_LO: begin
                    addr_d[7:0] = byte_val;
                    state_d     = ST_TYPE;
                end
                ST_TYPE: begin
                    type_d = byte_val;
                    if (byte_val == TYP_DATA || byte_val == TYP_EOF) begin
                        state_d = (cnt_q == '0) ? ST_CSUM : ST_DATA;
                    end else if (byte_val >= TYP_EXT_L && byte_val <= TYP_EXT_H) begin
                        unsup_d = 1'b1;
                        state_d = ST_HUNT;
                    end else begin
                        ferr_d  = 1'b1;
                        state_d = ST_HUNT;
                    end
                end
                ST_DATA: begin
                    wr_d   = (type_q == TYP_DATA);
                    addr_d = addr_q + 1'b1;
                    cnt_d  = cnt_q - 1'b1;
                    if (cnt_q == 8'd1) state_d = ST_CSUM;
                end
                ST_CSUM: begin
                    done_d = 1'b1;
                    if (sum_next != '0) begin
                        cerr_d  = 1'b1;
                        state_d = ST_HUNT;
                    end else if (type_q == TYP_EOF) begin
                        state_d = ST_EOF;
                    end else begin
                        state_d = ST_HUNT;
                    end
                end
                default: ;
            endcase
        end
    end

    // State and field registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            cnt_q   <= '0;
            addr_q  <= '0;
            type_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            addr_q  <= addr_d;
            type_q  <= type_d;
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            rec_done   <= 1'b0;
            csum_err   <= 1'b0;
            fmt_err    <= 1'b0;
            unsup_type <= 1'b0;
        end else begin
            wr_en      <= wr_d;
            rec_done   <= done_d;
            csum_err   <= cerr_d;
            fmt_err    <= ferr_d;
            unsup_type <= unsup_d;
            if (wr_d) begin
                wr_addr <= addr_q;
                wr_data <= byte_val;
            end
        end
    end

    assign eof_seen = (state_q == ST_EOF);
endmodule

// File: rtl/hexrec_parser_chk.sv
module hexrec_parser_chk (
    input logic clk,
    input logic rst_n,
    input logic char_valid,
    input logic wr_en,
    input logic rec_done,
    input logic csum_err,
    input logic fmt_err,
    input logic unsup_type,
    input logic eof_seen
);
    // R4: a byte takes two digit beats, so writes never come back to back
    a_r4_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
    // R4: every write follows an accepted character
    a_r4_wr_needs_char: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(char_valid));
    // R5: record completion follows an accepted character
    a_r5_done_needs_char: assert property (@(posedge clk) disable iff (!rst_n)
        rec_done |-> $past(char_valid));
    // R6: a checksum error is reported only as part of a finished record
    a_r6_cerr_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        csum_err |-> rec_done);
    // R7, R9: one event per cycle
    a_r7_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, rec_done, fmt_err, unsup_type}));
    // R8: end of file is sticky
    a_r8_eof_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        eof_seen |=> eof_seen);
    // R8: silence after end of file
    a_r8_quiet_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
        eof_seen |=> !(wr_en || rec_done || csum_err || fmt_err || unsup_type));
endmodule

bind hexrec_parser hexrec_parser_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .char_valid (char_valid),
    .wr_en      (wr_en),
    .rec_done   (rec_done),
    .csum_err   (csum_err),
    .fmt_err    (fmt_err),
    .unsup_type (unsup_type),
    .eof_seen   (eof_seen)
);

// File: tb/hexrec_parser_tb_top.sv
module hexrec_parser_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        char_valid;
    logic [7:0]  char_data;
    logic        wr_en;
    logic [15:0] wr_addr;
    logic [7:0]  wr_data;
    logic        rec_done, csum_err, fmt_err, unsup_type, eof_seen;

    int n_checks = 0;
    int n_fail   = 0;

    // behavioural reference state
    int m_st = 0;  // 0 hunt,1 count,2 addr hi,3 addr lo,4 type,5 data,6 csum,7 eof
    int m_ph, m_hi, m_sum, m_cnt, m_addr, m_typ;
    bit e_wr, e_done, e_cerr, e_ferr, e_unsup, e_eof;
    int e_addr, e_data;
    logic [7:0] mem [int];

    always #(CLK_PERIOD/2) clk = ~clk;

    hexrec_parser dut_i (
        .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_data(char_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rec_done(rec_done),
        .csum_err(csum_err), .fmt_err(fmt_err), .unsup_type(unsup_type),
        .eof_seen(eof_seen)
    );

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int hexval(byte c);
        if (c >= "0" && c <= "9") return c - "0";
        if (c >= "A" && c <= "F") return c - "A" + 10;
        if (c >= "a" && c <= "f") return c - "a" + 10;
        return -1;
    endfunction

    function automatic byte hexch(int v, bit lower);
        if (v < 10) return byte'("0" + v);
        return byte'((lower ? "a" : "A") + v - 10);
    endfunction

    task automatic model(bit v, byte c);
        int n, b;
        e_wr = 0; e_done = 0; e_cerr = 0; e_ferr = 0; e_unsup = 0;
        if (!v || m_st == 7) return;
        if (m_st == 0) begin
            if (c == ":") begin m_st = 1; m_ph = 0; m_sum = 0; end
            return;
        end
        n = hexval(c);
        if (n < 0) begin e_ferr = 1; m_st = 0; return; end
        if (m_ph == 0) begin m_hi = n; m_ph = 1; return; end
        m_ph = 0;
        b = m_hi * 16 + n;
        m_sum = (m_sum + b) % 256;
        case (m_st)
            1: if (b > 16) begin e_ferr = 1; m_st = 0; end
               else begin m_cnt = b; m_st = 2; end
            2: begin m_addr = b * 256; m_st = 3; end
            3: begin m_addr += b; m_st = 4; end
            4: begin
                m_typ = b;
                if (b <= 1) m_st = (m_cnt == 0) ? 6 : 5;
                else if (b <= 5) begin e_unsup = 1; m_st = 0; end
                else begin e_ferr = 1; m_st = 0; end
            end
            5: begin
                if (m_typ == 0) begin
                    e_wr = 1; e_addr = m_addr; e_data = b;
                end
                m_addr = (m_addr + 1) % 65536;
                m_cnt--;
                if (m_cnt == 0) m_st = 6;
            end
            6: begin
                e_done = 1;
                if (m_sum != 0) begin e_cerr = 1; m_st = 0; end
                else if (m_typ == 1) begin e_eof = 1; m_st = 7; end
                else m_st = 0;
            end
            default: ;
        endcase
    endtask

    // one clock: drive at negedge, compare registered outputs at the next negedge
    task automatic step(bit v, byte c);
        char_valid = v;
        char_data  = c;
        model(v, c);
        @(negedge clk);
        check("R4", "wr_en", wr_en, e_wr);
        if (e_wr) begin
            check("R4", "wr_addr", wr_addr, e_addr);
            check("R4", "wr_data", wr_data, e_data);
            mem[e_addr] = wr_data;
        end
        check("R5", "rec_done", rec_done, e_done);
        check("R6", "csum_err", csum_err, e_cerr);
        check("R3/R7", "fmt_err", fmt_err, e_ferr);
        check("R9", "unsup_type", unsup_type, e_unsup);
        check("R8", "eof_seen", eof_seen, e_eof);
        char_valid = 0;
    endtask

    task automatic send_str(string s);
        for (int i = 0; i < s.len(); i++) step(1, s[i]);
    endtask

    task automatic send_rec(int cnt, int addr, int typ, logic [7:0] d[$],
                            bit corrupt, bit lower, bit gaps);
        logic [7:0] bytes[$];
        int s = 0;
        bytes.push_back(8'(cnt));
        bytes.push_back(8'(addr >> 8));
        bytes.push_back(8'(addr));
        bytes.push_back(8'(typ));
        foreach (d[i]) bytes.push_back(d[i]);
        foreach (bytes[i]) s += bytes[i];
        bytes.push_back(8'((256 - (s % 256)) % 256 + (corrupt ? 1 : 0)));
        step(1, ":");
        foreach (bytes[i]) begin
            step(1, hexch(bytes[i] >> 4, lower));
            if (gaps) step(0, 8'h00);
            step(1, hexch(bytes[i] & 15, lower));
        end
        step(1, 8'h0D);
        step(1, 8'h0A);
    endtask

    initial begin
        logic [7:0] d[$];
        rst_n = 0; char_valid = 0; char_data = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "wr_en", wr_en, 0);
        check("R1", "rec_done", rec_done, 0);
        check("R1", "csum_err", csum_err, 0);
        check("R1", "fmt_err", fmt_err, 0);
        check("R1", "unsup_type", unsup_type, 0);
        check("R1", "eof_seen", eof_seen, 0);
        rst_n = 1;
        // R2: junk and line ends before a colon
        send_str("junk 07\r\n");
        // R6: reference record with checksum 35
        send_str(":0700200 0DBFEDCFADDF62235\r\n");
        send_str(":07002000DBFEDCFADDF62235\r\n");
        check("R6", "mem[0x26]", mem[32'h26], 8'h22);
        // R4: lower-case digits, address wrap, idle gaps
        d = '{8'hA1, 8'hB2, 8'hC3};
        send_rec(3, 16'hFFFE, 0, d, 0, 1, 1);
        check("R4", "mem[0x0000]", mem[0], 8'hC3);
        // R6: bad checksum, writes stand
        d = '{8'h11, 8'h22};
        send_rec(2, 16'h0100, 0, d, 1, 0, 0);
        check("R6", "mem[0x0101]", mem[32'h101], 8'h22);
        // R3: count 0x11 is too big
        d = {};
        for (int i = 0; i < 17; i++) d.push_back(8'(i));
        send_rec(17, 16'h0200, 0, d, 0, 0, 0);
        // R4: maximum count 0x10
        d = {};
        for (int i = 0; i < 16; i++) d.push_back(8'(8'h40 + i));
        send_rec(16, 16'h0300, 0, d, 0, 0, 0);
        // R5: zero-count data record
        d = {};
        send_rec(0, 16'h1234, 0, d, 0, 0, 0);
        // R7: non-hex character inside a record, then a fresh record
        send_str(":0300G0\r\n:0310");
        d = '{8'h5A};
        send_rec(1, 16'h0400, 0, d, 0, 0, 0);
        // R9: extended-address and unknown types
        d = '{8'h00, 8'h10};
        send_rec(2, 16'h0000, 4, d, 0, 0, 0);
        send_rec(2, 16'h0000, 7, d, 0, 0, 0);
        // R8: end of file, then everything ignored
        send_str(":00000001FF\r\n");
        d = '{8'h99};
        send_rec(1, 16'h0500, 0, d, 0, 0, 0);
        send_str(":G");
        check("R8", "no write after eof", int'(mem.exists(32'h500)), 0);
        repeat (4) step(0, 8'h00);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule